// File: doc/BRIEF.md
# Drive Mailbox Status Export and Command Decode

This block sits between an optical drive controller and the processor that reads the drive mailbox. On an export strobe it packs a drive report into a ten-byte status area. The report is four 16-bit words (the drive status word it holds itself, plus minute, second and frame values from its inputs) and one extension byte. It then computes a 4-bit integrity nibble, trims the mailbox control register down to its two lowest bits and, when the interrupt mask allows it, pulses an interrupt request.

On an import strobe it decodes the command code, and for table-of-contents queries a sub-code as well. It produces a one-hot operation select for the engine that carries out drive operations. For table-of-contents queries it also records the query kind in the low byte of the held status word, so that the next export reports it.

Top module: `drive_mailbox`

## Requirements
- R1: During and after reset, `statusArea` is all zero except byte 9 (bits 79:72), which reads 0x0F. `ctrlOut` is 0, and `irqPulse` and `opValid` are 0.
- R2: In the cycle after an `exportStb` edge, byte 2k holds the low byte of word k and byte 2k+1 holds its high byte. Word order is k=0 held status, 1 minute, 2 second, 3 frame. Byte 8 holds `extIn`. Byte n of the area is bits 8n+7:8n.
- R3: After an export, byte 9 equals the bitwise inverse of the sum of bytes 0 to 8, taken modulo 16, with its upper nibble zero.
- R4: An export leaves `ctrlOut` with bits 1:0 unchanged and bits 7:2 cleared. A `ctrlWe` in the same cycle as an export is discarded.
- R5: `irqPulse` is high for exactly the cycle after an export strobe taken with `irqEnable` high, and is low at all other times.
- R6: In the cycle after `importStb`, `opValid` is 1 and exactly one bit of `opSel` is set. The bit index is: code 0→0, 1→1, 2→2, 3→3, 4→4, 6→5, 7→6, 8→7, 9→8, 0x0A→9, 0x0C→10, 0x0D→11, any other code→12. At all other times `opValid` is 0 and `opSel` is 0.
- R7: A code-2 import with sub-code 0 to 5 selects bit 2 and replaces the low byte of the held status word with the sub-code. The high byte is kept.
- R8: A code-2 import with any other sub-code selects bit 0 and writes 0x0F into the held status low byte. The high byte is kept.
- R9: `statusWe` loads the held status word. Imports of codes other than 2 leave it unchanged. A code-2 import in the same cycle as `statusWe` takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statusWe | input | 1 | Load held status word |
| statusIn | input | 16 | New held status word |
| minuteIn | input | 16 | Minute word for export |
| secondIn | input | 16 | Second word for export |
| frameIn | input | 16 | Frame word for export |
| extIn | input | 8 | Extension byte for export |
| exportStb | input | 1 | Export request |
| irqEnable | input | 1 | Interrupt mask bit for export reports |
| ctrlWe | input | 1 | Host write of control register |
| ctrlIn | input | 8 | Control register write data |
| importStb | input | 1 | Command import request |
| cmdCode | input | 8 | Command code byte |
| cmdSub | input | 8 | Command sub-code byte (table-of-contents kind) |
| statusArea | output | 80 | Ten-byte status area, byte n at bits 8n+7:8n |
| ctrlOut | output | 8 | Control register |
| irqPulse | output | 1 | Export interrupt request |
| opSel | output | 13 | One-hot operation select |
| opValid | output | 1 | Operation select valid |

## Verification
Every result has one register stage. The status area, control trim and interrupt pulse appear in the cycle after the export strobe, and the operation select appears in the cycle after the import strobe. The held-status update from an import becomes visible only through the next export, one further cycle on. The bench drives each stimulus for a single cycle on the falling edge and samples on the falling edge after the next rising edge. One cycle later it samples again to confirm that the pulse-type outputs have returned to zero. It sweeps all 256 command codes and all 256 sub-codes, and runs a few hundred arithmetically generated export patterns with checksums computed by byte summation.

// File: rtl/mailbox_pkg.sv
`timescale 1ns/1ps
package mailbox_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 16;
  localparam int NUM_WORDS  = 4;
  localparam int AREA_BYTES = 2 * NUM_WORDS + 2;
  localparam int AREA_W     = AREA_BYTES * BYTE_W;
  localparam int CSUM_W     = 4;
  localparam int SUM_W      = WORD_W + 4;
  localparam int CTRL_W     = 8;
  localparam int CTRL_KEEP  = 2;
  localparam int NUM_OPS    = 13;

  localparam int OP_STATUS = 0;
  localparam int OP_STOP   = 1;
  localparam int OP_TOC    = 2;
  localparam int OP_READ   = 3;
  localparam int OP_SEEK   = 4;
  localparam int OP_PAUSE  = 5;
  localparam int OP_RESUME = 6;
  localparam int OP_FFWD   = 7;
  localparam int OP_REWIND = 8;
  localparam int OP_REINIT = 9;
  localparam int OP_CLOSE  = 10;
  localparam int OP_OPEN   = 11;
  localparam int OP_OTHER  = 12;

  localparam logic [BYTE_W-1:0] CMD_TOC      = 8'h02;
  localparam logic [BYTE_W-1:0] TOC_LAST     = 8'h05;
  localparam logic [BYTE_W-1:0] TOC_FALLBACK = 8'h0F;

  typedef struct packed {
    logic              exportNow;
    logic              tocLoad;
    logic [BYTE_W-1:0] tocCode;
  } mbStrobes_t;
endpackage

// File: rtl/mailbox_ctrl.sv
`timescale 1ns/1ps
module mailbox_ctrl
  import mailbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               exportStb,
  input  logic               importStb,
  input  logic [BYTE_W-1:0]  cmdCode,
  input  logic [BYTE_W-1:0]  cmdSub,
  output mbStrobes_t         strobes,
  output logic [NUM_OPS-1:0] opSel,
  output logic               opValid
);
  logic               tocOk;
  logic [NUM_OPS-1:0] nextSel;
  int                 opIdx;

  assign tocOk = (cmdSub <= TOC_LAST);

  always_comb begin
    case (cmdCode)
      8'h00:   opIdx = OP_STATUS;
      8'h01:   opIdx = OP_STOP;
      8'h02:   opIdx = tocOk ? OP_TOC : OP_STATUS;
      8'h03:   opIdx = OP_READ;
      8'h04:   opIdx = OP_SEEK;
      8'h06:   opIdx = OP_PAUSE;
      8'h07:   opIdx = OP_RESUME;
      8'h08:   opIdx = OP_FFWD;
      8'h09:   opIdx = OP_REWIND;
      8'h0A:   opIdx = OP_REINIT;
      8'h0C:   opIdx = OP_CLOSE;
      8'h0D:   opIdx = OP_OPEN;
      default: opIdx = OP_OTHER;
    endcase
    nextSel = '0;
    nextSel[opIdx] = 1'b1;
  end

  always_comb begin
    strobes.exportNow = exportStb;
    strobes.tocLoad   = importStb && (cmdCode == CMD_TOC);
    strobes.tocCode   = tocOk ? cmdSub : TOC_FALLBACK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opValid <= 1'b0;
      opSel   <= '0;
    end else begin
      opValid <= importStb;
      opSel   <= importStb ? nextSel : '0;
    end
  end

  a_r6_onehot_when_valid: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> ($countones(opSel) == 1));
  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (opSel == '0));
  a_r6_one_cycle_after: assert property (@(posedge clk) disable iff (!rstN)
    importStb |=> opValid);
endmodule

// File: rtl/mailbox_dp.sv
`timescale 1ns/1ps
module mailbox_dp
  import mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mbStrobes_t        strobes,
  input  logic              statusWe,
  input  logic [WORD_W-1:0] statusIn,
  input  logic [WORD_W-1:0] minuteIn,
  input  logic [WORD_W-1:0] secondIn,
  input  logic [WORD_W-1:0] frameIn,
  input  logic [BYTE_W-1:0] extIn,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  logic              irqEnable,
  output logic [AREA_W-1:0] statusArea,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              irqPulse
);
  localparam logic [AREA_W-1:0] RST_AREA =
    {{(BYTE_W-CSUM_W){1'b0}}, {CSUM_W{1'b1}}, {(AREA_W-BYTE_W){1'b0}}};

  logic [WORD_W-1:0]                 statusReg;
  logic [NUM_WORDS-1:0][WORD_W-1:0]  words;
  logic [SUM_W-1:0]                  partial [NUM_WORDS+1];
  logic [BYTE_W-1:0]                 csumByte;

  assign words      = {frameIn, secondIn, minuteIn, statusReg};
  assign partial[0] = SUM_W'(extIn);

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_sum
    assign partial[k+1] = partial[k] + SUM_W'(words[k])
                        + SUM_W'(words[k][WORD_W-1:BYTE_W]);
  end

  assign csumByte = {{(BYTE_W-CSUM_W){1'b0}}, ~partial[NUM_WORDS][CSUM_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusArea <= RST_AREA;
      ctrlOut    <= '0;
      irqPulse   <= 1'b0;
      statusReg  <= '0;
    end else begin
      irqPulse <= strobes.exportNow && irqEnable;
      if (strobes.exportNow) begin
        statusArea <= {csumByte, extIn, words};
        ctrlOut    <= {{(CTRL_W-CTRL_KEEP){1'b0}}, ctrlOut[CTRL_KEEP-1:0]};
      end else if (ctrlWe) begin
        ctrlOut <= ctrlIn;
      end
      if (strobes.tocLoad)
        statusReg <= {statusReg[WORD_W-1:BYTE_W], strobes.tocCode};
      else if (statusWe)
        statusReg <= statusIn;
    end
  end

  a_r4_ctrl_trimmed: assert property (@(posedge clk) disable iff (!rstN)
    strobes.exportNow |=> (ctrlOut[CTRL_W-1:CTRL_KEEP] == '0));
  a_r4_ctrl_low_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.exportNow |=> (ctrlOut[CTRL_KEEP-1:0] == $past(ctrlOut[CTRL_KEEP-1:0])));
  a_r5_irq_from_export: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(strobes.exportNow && irqEnable));
  a_r3_csum_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.exportNow |=> (statusArea[AREA_W-1 -: (BYTE_W-CSUM_W)] == '0));
  a_r7_high_byte_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tocLoad |=> (statusReg[WORD_W-1:BYTE_W] == $past(statusReg[WORD_W-1:BYTE_W])));
endmodule

// File: rtl/drive_mailbox.sv
`timescale 1ns/1ps
module drive_mailbox
  import mailbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               statusWe,
  input  logic [15:0]        statusIn,
  input  logic [15:0]        minuteIn,
  input  logic [15:0]        secondIn,
  input  logic [15:0]        frameIn,
  input  logic [7:0]         extIn,
  input  logic               exportStb,
  input  logic               irqEnable,
  input  logic               ctrlWe,
  input  logic [7:0]         ctrlIn,
  input  logic               importStb,
  input  logic [7:0]         cmdCode,
  input  logic [7:0]         cmdSub,
  output logic [79:0]        statusArea,
  output logic [7:0]         ctrlOut,
  output logic               irqPulse,
  output logic [12:0]        opSel,
  output logic               opValid
);
  mbStrobes_t strobes;

  mailbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .exportStb(exportStb), .importStb(importStb),
    .cmdCode(cmdCode), .cmdSub(cmdSub), .strobes(strobes),
    .opSel(opSel), .opValid(opValid)
  );

  mailbox_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusWe(statusWe),
    .statusIn(statusIn), .minuteIn(minuteIn), .secondIn(secondIn),
    .frameIn(frameIn), .extIn(extIn), .ctrlWe(ctrlWe), .ctrlIn(ctrlIn),
    .irqEnable(irqEnable), .statusArea(statusArea), .ctrlOut(ctrlOut),
    .irqPulse(irqPulse)
  );
endmodule

// File: tb/test_drive_mailbox.sv
`timescale 1ns/1ps
module test_drive_mailbox;
  logic clk = 1'b0, rstN = 1'b0;
  logic statusWe = 0, exportStb = 0, irqEnable = 0, ctrlWe = 0, importStb = 0;
  logic [15:0] statusIn = 0, minuteIn = 0, secondIn = 0, frameIn = 0;
  logic [7:0] extIn = 0, ctrlIn = 0, cmdCode = 0, cmdSub = 0;
  logic [79:0] statusArea;
  logic [7:0] ctrlOut;
  logic irqPulse, opValid;
  logic [12:0] opSel;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  drive_mailbox i_drive_mailbox (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int expIdx(logic [7:0] c, logic [7:0] s);
    case (c)
      8'h00: return 0;  8'h01: return 1;
      8'h02: return (s <= 8'h05) ? 2 : 0;
      8'h03: return 3;  8'h04: return 4;  8'h06: return 5;  8'h07: return 6;
      8'h08: return 7;  8'h09: return 8;  8'h0A: return 9;  8'h0C: return 10;
      8'h0D: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic logic [79:0] expArea(logic [15:0] s, m, se, f, logic [7:0] e);
    logic [71:0] body = {e, f[15:8], f[7:0], se[15:8], se[7:0], m[15:8], m[7:0], s[15:8], s[7:0]};
    int sum = 0;
    for (int b = 0; b < 9; b++) sum += body[8*b +: 8];
    return {4'h0, 4'(~sum), body};
  endfunction

  task automatic setStatus(logic [15:0] v);
    statusWe = 1; statusIn = v; tick(); statusWe = 0;
  endtask

  task automatic doExport(logic en);
    exportStb = 1; irqEnable = en; tick(); exportStb = 0; irqEnable = 0;
  endtask

  task automatic doImport(logic [7:0] c, logic [7:0] s);
    importStb = 1; cmdCode = c; cmdSub = s; tick(); importStb = 0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) tick();
    chk("R1 area", statusArea, {8'h0F, 72'h0});
    rstN = 1; tick();
    chk("R1 area after release", statusArea, {8'h0F, 72'h0});
    chk("R1 ctrl", 80'(ctrlOut), 80'h0);
    chk("R1 irq/valid", {78'h0, irqPulse, opValid}, 80'h0);

    // R2 R3 R5: export patterns
    for (int i = 0; i < 300; i++) begin
      held     = 16'(i * 40503 + 7);
      minuteIn = 16'(i * 2654 + 3);
      secondIn = 16'(i * 977 ^ 16'hA5C3);
      frameIn  = 16'(i * 31337);
      extIn    = 8'(i * 13);
      setStatus(held);
      doExport(i[0]);
      chk("R2/R3 area", statusArea, expArea(held, minuteIn, secondIn, frameIn, extIn));
      chk("R5 irq", 80'(irqPulse), 80'(i[0]));
      tick();
      chk("R5 irq drops", 80'(irqPulse), 80'h0);
    end

    // R4 control trim
    ctrlWe = 1; ctrlIn = 8'hFF; tick(); ctrlWe = 0;
    chk("R4 ctrl write", 80'(ctrlOut), 80'hFF);
    doExport(0);
    chk("R4 ctrl trimmed", 80'(ctrlOut), 80'h03);
    ctrlWe = 1; ctrlIn = 8'hFE; tick(); ctrlWe = 0;
    doExport(0);
    chk("R4 ctrl trimmed 2", 80'(ctrlOut), 80'h02);
    ctrlWe = 1; ctrlIn = 8'h55; exportStb = 1; tick(); ctrlWe = 0; exportStb = 0;
    chk("R4 export beats write", 80'(ctrlOut), 80'h02);

    // R6 R9: all command codes, status must survive non-TOC codes
    for (int c = 0; c < 256; c++) begin
      setStatus(16'hC3A1);
      doImport(8'(c), 8'h09);
      chk("R6 valid", 80'(opValid), 80'h1);
      chk("R6 select", 80'(opSel), 80'(13'b1 << expIdx(8'(c), 8'h09)));
      tick();
      chk("R6 idle", {79'(opSel), opValid}, 80'h0);
      if (c != 2) begin
        minuteIn = 0; secondIn = 0; frameIn = 0; extIn = 0;
        doExport(0);
        chk("R9 status unchanged", 80'(statusArea[15:0]), 80'hC3A1);
      end
    end

    // R7 R8: all sub-codes
    for (int s = 0; s < 256; s++) begin
      setStatus(16'h5A77);
      doImport(8'h02, 8'(s));
      chk(s <= 5 ? "R7 select" : "R8 select", 80'(opSel),
          80'(13'b1 << ((s <= 5) ? 2 : 0)));
      doExport(0);
      chk(s <= 5 ? "R7 status" : "R8 status", 80'(statusArea[15:0]),
          80'({8'h5A, (s <= 5) ? 8'(s) : 8'h0F}));
    end

    // R9: write then TOC import in same cycle
    setStatus(16'h1111);
    statusWe = 1; statusIn = 16'hEEEE; importStb = 1; cmdCode = 8'h02; cmdSub = 8'h03;
    tick(); statusWe = 0; importStb = 0;
    doExport(0);
    chk("R9 toc over write", 80'(statusArea[15:0]), 80'h1103);
    setStatus(16'hBEEF);
    doExport(0);
    chk("R9 status load", 80'(statusArea[15:0]), 80'hBEEF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule